// File: doc/BRIEF.md
# Performance Update Strobe Controller

This block produces the level that tells a group of performance counters to copy their running totals into holding registers and restart from zero. The level can come from one of four sources: a once-per-second tick from the chip timebase, an external general-purpose pin, a control bit owned by this port, or a control bit shared by all ports. A two-bit select field picks the source. The pin is asynchronous, so it passes through a synchronizer before selection.

Alongside the update level, the block reports completion through a status level. That status follows the update level after a fixed delay, which gives the counters time to finish their transfer. Software that drives the update through a control bit sets the bit, waits for the status to go high, and then clears the bit so that the next update can start. A hardware source is handled the same way: the status goes high a little after the source rises and low a little after it falls.

A sticky flag records each rising edge of the status. Software clears it with a write-one-to-clear pulse, and the flag ANDed with an enable drives an interrupt. The port's status reaches the chip-wide status only when the port takes its update from the shared global bit. In every other case the port is masked out of the global status.

Top module: `perf_update_ctrl`

## Requirements
- R1: With `srcSel` = 2'b00, `pmuOut` after a clock edge equals `secTick` as sampled at that edge, so there is one cycle of latency.
- R2: With `srcSel` = 2'b01, `pmuOut` after clock edge n equals `gpioPin` as sampled at edge n-2. The pin passes through a two-flop synchronizer and then the output register, so there are three cycles of latency.
- R3: With `srcSel` = 2'b10, `pmuOut` follows `portCtlBit` with one cycle of latency. With `srcSel` = 2'b11, it follows `globCtlBit` with one cycle of latency.
- R4: `pms` after clock edge n equals `pmuOut` after edge n-2. A software handshake therefore sees `pms` rise two cycles after `pmuOut` rises.
- R5: `pms` falls exactly two cycles after `pmuOut` falls, so `pms` goes low soon after a hardware source goes low.
- R6: `pmsLatched` is set at the edge where `pms` goes from 0 to 1. If `latchClr` is high at that same edge, the set wins.
- R7: `pmsLatched` stays set until an edge where `latchClr` is high and `pms` is not rising. At that edge it clears.
- R8: `pmsIrq` equals `pmsLatched` AND `intEn`.
- R9: `globPms` equals `pms` when `srcSel` = 2'b11 and is 0 for every other select value.
- R10: While `rst_n` is low, all outputs and all internal state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-second tick from the timebase (synchronous) |
| gpioPin | input | 1 | General-purpose pin used as an update source (asynchronous) |
| portCtlBit | input | 1 | Per-port software update bit |
| globCtlBit | input | 1 | Chip-wide software update bit |
| srcSel | input | 2 | Source select: 00 tick, 01 pin, 10 port bit, 11 global bit |
| latchClr | input | 1 | Write-one-to-clear pulse for the latched status |
| intEn | input | 1 | Interrupt enable |
| pmuOut | output | 1 | Update level sent to the counters |
| pms | output | 1 | Update status, the delayed copy of `pmuOut` |
| pmsLatched | output | 1 | Sticky flag set on each rising edge of `pms` |
| pmsIrq | output | 1 | Interrupt request |
| globPms | output | 1 | This port's contribution to the global status |

## Verification
The hardest case to reach from the ports is a clear pulse that lands on the same edge where `pms` rises. In that case the set must win. To reach it, the bench needs to know the full source-to-status latency. It raises the port bit and then asserts `latchClr` exactly two falling edges later, so that the pulse is sampled on the edge where `pms` rises. A long random phase follows. It switches the select field in the middle of a handshake and lets the pin toggle, which checks the extra synchronizer delay against the other sources.

// File: rtl/perf_update_pkg.sv
package perf_update_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_TICK   = 2'b00,
    SRC_PIN    = 2'b01,
    SRC_PORT   = 2'b10,
    SRC_GLOBAL = 2'b11
  } srcSel_e;

  // Strobes from the control half to the flag datapath
  typedef struct packed {
    logic pmsLevel;
    logic pmsRise;
    logic globalSel;
  } ctlStrobes_t;

endpackage

// File: rtl/perf_update_sync.sv
module perf_update_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[i] <= 1'b0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/perf_update_sel.sv
module perf_update_sel
  import perf_update_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PMS_DELAY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             secTick,
  input  logic             gpioPin,
  input  logic             portCtlBit,
  input  logic             globCtlBit,
  input  logic [SEL_W-1:0] srcSel,
  output logic             pmuOut,
  output ctlStrobes_t      strobes
);
  localparam int LAST = PMS_DELAY - 1;

  logic pinSync;
  logic selLevel;
  logic [PMS_DELAY-1:0] pmsPipe;

  perf_update_sync #(.STAGES(SYNC_STAGES)) u_pinSync (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn(gpioPin),
    .syncOut(pinSync)
  );

  always_comb begin
    unique case (srcSel_e'(srcSel))
      SRC_TICK:   selLevel = secTick;
      SRC_PIN:    selLevel = pinSync;
      SRC_PORT:   selLevel = portCtlBit;
      SRC_GLOBAL: selLevel = globCtlBit;
      default:    selLevel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pmuOut <= 1'b0;
    else        pmuOut <= selLevel;
  end

  // Completion status trails the update level by PMS_DELAY cycles
  always_ff @(posedge clk) begin
    if (!rst_n) pmsPipe <= '0;
    else        pmsPipe <= {pmsPipe[LAST-1:0], pmuOut};
  end

  assign strobes.pmsLevel  = pmsPipe[LAST];
  assign strobes.pmsRise   = pmsPipe[LAST-1] & ~pmsPipe[LAST];
  assign strobes.globalSel = (srcSel == SRC_GLOBAL);

  a_r1_tick_path: assert property (@(posedge clk) disable iff (!rst_n)
    (srcSel == SRC_TICK) |=> (pmuOut == $past(secTick)));

  a_r3_port_path: assert property (@(posedge clk) disable iff (!rst_n)
    (srcSel == SRC_PORT) |=> (pmuOut == $past(portCtlBit)));

  a_r4_pms_trails_pmu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.pmsLevel) |-> $past(pmuOut, PMS_DELAY));

  a_r5_pms_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobes.pmsLevel) |-> !$past(pmuOut, PMS_DELAY));
endmodule

// File: rtl/perf_update_flag.sv
module perf_update_flag
  import perf_update_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrobes_t strobes,
  input  logic        latchClr,
  input  logic        intEn,
  output logic        pms,
  output logic        pmsLatched,
  output logic        pmsIrq,
  output logic        globPms
);
  always_ff @(posedge clk) begin
    if (!rst_n)                pmsLatched <= 1'b0;
    else if (strobes.pmsRise)  pmsLatched <= 1'b1;
    else if (latchClr)         pmsLatched <= 1'b0;
  end

  assign pms     = strobes.pmsLevel;
  assign pmsIrq  = pmsLatched & intEn;
  assign globPms = strobes.pmsLevel & strobes.globalSel;

  a_r6_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pms) |-> pmsLatched);

  a_r7_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (latchClr && !strobes.pmsRise) |=> !pmsLatched);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pmsLatched && !latchClr) |=> pmsLatched);

  a_r9_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    globPms |-> (pms && strobes.globalSel));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    pmsIrq |-> (pmsLatched && intEn));
endmodule

// File: rtl/perf_update_ctrl.sv
module perf_update_ctrl
  import perf_update_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PMS_DELAY   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secTick,
  input  logic       gpioPin,
  input  logic       portCtlBit,
  input  logic       globCtlBit,
  input  logic [1:0] srcSel,
  input  logic       latchClr,
  input  logic       intEn,
  output logic       pmuOut,
  output logic       pms,
  output logic       pmsLatched,
  output logic       pmsIrq,
  output logic       globPms
);
  ctlStrobes_t strobes;

  perf_update_sel #(
    .SYNC_STAGES(SYNC_STAGES),
    .PMS_DELAY  (PMS_DELAY)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .secTick   (secTick),
    .gpioPin   (gpioPin),
    .portCtlBit(portCtlBit),
    .globCtlBit(globCtlBit),
    .srcSel    (srcSel),
    .pmuOut    (pmuOut),
    .strobes   (strobes)
  );

  perf_update_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .latchClr  (latchClr),
    .intEn     (intEn),
    .pms       (pms),
    .pmsLatched(pmsLatched),
    .pmsIrq    (pmsIrq),
    .globPms   (globPms)
  );

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!pmuOut && !pms && !pmsLatched));
endmodule

// File: tb/perf_update_ctrl_tb.sv
`timescale 1ns/1ps
module perf_update_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic secTick = 0, gpioPin = 0, portCtlBit = 0, globCtlBit = 0;
  logic [1:0] srcSel = 2'b00;
  logic latchClr = 0, intEn = 0;
  logic pmuOut, pms, pmsLatched, pmsIrq, globPms;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_update_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .gpioPin(gpioPin),
    .portCtlBit(portCtlBit), .globCtlBit(globCtlBit), .srcSel(srcSel),
    .latchClr(latchClr), .intEn(intEn), .pmuOut(pmuOut), .pms(pms),
    .pmsLatched(pmsLatched), .pmsIrq(pmsIrq), .globPms(globPms)
  );

  // Behavioural reference model
  int pinHist[$] = '{0, 0};
  int pmuHist[$] = '{0, 0};
  int mPmu = 0, mPms = 0, mLat = 0;

  always @(posedge clk) begin
    int lvl, newPms;
    if (!rst_n) begin
      pinHist = '{0, 0};
      pmuHist = '{0, 0};
      mPmu = 0; mPms = 0; mLat = 0;
    end else begin
      case (srcSel)
        2'b00:   lvl = secTick;
        2'b01:   lvl = pinHist[1];
        2'b10:   lvl = portCtlBit;
        default: lvl = globCtlBit;
      endcase
      newPms = pmuHist[1];
      pinHist.push_front(int'(gpioPin)); void'(pinHist.pop_back());
      pmuHist.push_front(lvl);           void'(pmuHist.pop_back());
      if (newPms == 1 && mPms == 0) mLat = 1;
      else if (latchClr)            mLat = 0;
      mPms = newPms;
      mPmu = lvl;
    end
  end

  task automatic checkOne(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string selReq;
    case (srcSel)
      2'b00:   selReq = "R1";
      2'b01:   selReq = "R2";
      default: selReq = "R3";
    endcase
    if (!rst_n) selReq = "R10";
    checkOne(selReq, "pmuOut", pmuOut, mPmu);
    checkOne(rst_n ? "R4 R5" : "R10", "pms", pms, mPms);
    checkOne(rst_n ? "R6 R7" : "R10", "pmsLatched", pmsLatched, mLat);
    checkOne("R8", "pmsIrq", pmsIrq, mLat & int'(intEn));
    checkOne("R9", "globPms", globPms, (mPms != 0 && srcSel == 2'b11) ? 1 : 0);
  endtask

  // Each cycle: compare on the falling edge, then drive the next inputs
  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    // R10: reset state
    repeat (4) step();
    rst_n = 1'b1;
    step();

    // R3, R4: software handshake on the port bit
    srcSel = 2'b10; intEn = 1;
    portCtlBit = 1;
    while (!pms) step();
    portCtlBit = 0;
    repeat (4) step();
    latchClr = 1; step(); latchClr = 0;   // R7 clear
    repeat (2) step();

    // R6: clear pulse on the same edge pms rises; set must win
    portCtlBit = 1; step(); step();
    latchClr = 1; step(); latchClr = 0;
    repeat (3) step();
    portCtlBit = 0; repeat (4) step();

    // R1: tick pulses, R5 hardware drop
    srcSel = 2'b00;
    repeat (3) begin secTick = 1; step(); secTick = 0; repeat (5) step(); end

    // R2: pin through synchronizer
    srcSel = 2'b01;
    gpioPin = 1; repeat (6) step(); gpioPin = 0; repeat (6) step();

    // R9: global bit with mask active, then switch away
    srcSel = 2'b11; globCtlBit = 1; repeat (5) step();
    srcSel = 2'b10; step(); step();
    globCtlBit = 0; srcSel = 2'b11; repeat (5) step();

    // Random phase across all sources, clears and enables
    for (int i = 0; i < 4000; i++) begin
      secTick    = ($urandom_range(0, 7) == 0);
      gpioPin    = ($urandom_range(0, 3) == 0) ? ~gpioPin : gpioPin;
      portCtlBit = ($urandom_range(0, 4) == 0) ? ~portCtlBit : portCtlBit;
      globCtlBit = ($urandom_range(0, 4) == 0) ? ~globCtlBit : globCtlBit;
      if ($urandom_range(0, 15) == 0) srcSel = 2'($urandom_range(0, 3));
      latchClr   = ($urandom_range(0, 5) == 0);
      intEn      = ($urandom_range(0, 9) != 0);
      if (i == 2000) rst_n = 1'b0;
      if (i == 2003) rst_n = 1'b1;
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule